// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words are 9 bits wide. The depth is a power of two set by a parameter, so simulation can use a small buffer and silicon can use a larger one. Each pointer crosses into the other clock domain as Gray code through a two-stage synchronizer.

The read timing is fixed at master reset by the `mode_sel` input, and the chosen mode holds until the next master reset.

- **Standard timing:** a word reaches `rd_data` one read-clock edge after a read request.
- **Fall-through timing:** the oldest word is placed on `rd_data` without any request. `rd_en` then acts as an acknowledge that pops it.

The mode also changes what the two status pins mean. A partial reset empties the buffer and keeps the mode. A retransmit request moves only the read side back to the first stored word, so earlier data can be read again.

The almost-full and almost-empty thresholds come in on ports from a separate offset block. Each threshold may be 0 to DEPTH. Retransmit is valid only while no more than DEPTH words have been written since the last reset.

Top module: `twoclk_fifo`

## Requirements
- R1: While `mrst` is high on both clocks, `rd_data` goes to 0. After release the buffer is empty: `rd_stat`=0 in standard timing, `wr_stat`=1, `almost_full_n`=1, `half_full_n`=1, and `almost_empty_n`=0 when `empty_off`>0.
- R2: `mode_sel` is captured only while `mrst` is high: 0 selects standard timing and 1 selects fall-through timing. The mode then ignores `mode_sel` until the next master reset.
- R3: Holding `prst` high empties the buffer and sets `rd_data` to 0, but keeps the timing mode.
- R4: A `retx` pulse on a read-clock edge shows the empty indication on the next edge: `rd_stat`=0 in standard timing, `rd_stat`=1 in fall-through timing. Reading then restarts from the first word written since reset.
- R5: `wr_stat` is 0 when the buffer is full in standard timing. In fall-through timing it is 0 while there is room for a write.
- R6: `rd_stat` is 0 when the buffer is empty in standard timing. In fall-through timing it is 0 while a valid word is on `rd_data`.
- R7: In standard timing, words come out in write order, one read-clock edge after `rd_en`. A read of an empty buffer leaves `rd_data` unchanged.
- R8: In fall-through timing, the first word appears on `rd_data` with no `rd_en`. Together with the output register the buffer holds DEPTH+1 words.
- R9: A write while the buffer is full is discarded.
- R10: `almost_full_n` is 0 when the stored word count exceeds DEPTH minus `full_off`.
- R11: `almost_empty_n` is 0 when the stored word count is below `empty_off`.
- R12: `half_full_n` is 0 when the stored word count exceeds DEPTH/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high; hold it for several edges of both clocks |
| prst | input | 1 | Partial reset, active high; keeps the timing mode |
| mode_sel | input | 1 | Timing mode sampled during master reset: 1 = fall-through |
| full_off | input | ADDR_W+1 | Almost-full threshold m |
| empty_off | input | ADDR_W+1 | Almost-empty threshold n |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read request (standard) or pop acknowledge (fall-through) |
| retx | input | 1 | Retransmit request, read clock |
| rd_data | output | DATA_W | Registered read word |
| wr_stat | output | 1 | Full flag (standard) or room-available flag (fall-through), active low |
| rd_stat | output | 1 | Empty flag (standard) or data-valid flag (fall-through), active low |
| almost_full_n | output | 1 | Almost-full, active low |
| almost_empty_n | output | 1 | Almost-empty, active low |
| half_full_n | output | 1 | Above half capacity, active low |

## Verification
The hardest state to reach is fall-through timing holding DEPTH+1 words. It needs the first word already moved into the output register, and that word's read-pointer advance already synchronized back to the write side, before the memory is filled.

The bench gets there in three steps:
1. Write a single word.
2. Wait until both pointer crossings have settled.
3. Write DEPTH more words, then drain all of them while checking order.

A second hard case is telling partial reset apart from master reset. After a partial reset, the read-side pin gives opposite levels in the two modes, so the bench checks it to show that the mode survived.

// File: rtl/twoclk_fifo_pkg.sv
package twoclk_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/twoclk_fifo_sync.sv
module twoclk_fifo_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/twoclk_fifo_ram.sv
module twoclk_fifo_ram #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    q <= '0;
    else if (re) q <= store[raddr];
  end
endmodule

// File: rtl/twoclk_fifo_wr.sv
module twoclk_fifo_wr
  import twoclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              mode_sel,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   full_off,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic [ADDR_W:0]   wgray,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic              wr_stat,
  output logic              almost_full_n,
  output logic              half_full_n
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);
  localparam logic [PW-1:0] HALF_P  = PW'(1 << (ADDR_W - 1));

  logic          rst;
  fifo_mode_e    mode_q;
  logic [PW-1:0] wbin_q, wgray_q, rbin, wbin_nxt, wcount_nxt;
  logic          full_q, af_n_q, hf_n_q, accept;

  assign rst = mrst | prst;

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
  end

  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_sync >> i);
  end

  assign accept     = wr_en & ~full_q;
  assign wbin_nxt   = wbin_q + {{(PW-1){1'b0}}, accept};
  assign wcount_nxt = wbin_nxt - rbin;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      af_n_q  <= 1'b1;
      hf_n_q  <= 1'b1;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      full_q  <= (wcount_nxt == DEPTH_P);
      af_n_q  <= !(wcount_nxt > (DEPTH_P - full_off));
      hf_n_q  <= !(wcount_nxt > HALF_P);
    end
  end

  assign wgray         = wgray_q;
  assign mem_we        = accept;
  assign mem_waddr     = wbin_q[ADDR_W-1:0];
  assign wr_stat       = (mode_q == MODE_FWFT) ? full_q : ~full_q;
  assign almost_full_n = af_n_q;
  assign half_full_n   = hf_n_q;

  // R9
  wr_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wbin_q - rbin) <= DEPTH_P);

  // R2
  wr_mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    !mrst |=> $stable(mode_q));
endmodule

// File: rtl/twoclk_fifo_rd.sv
module twoclk_fifo_rd
  import twoclk_fifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              mode_sel,
  input  logic              rd_en,
  input  logic              retx,
  input  logic [ADDR_W:0]   empty_off,
  input  logic [ADDR_W:0]   wgray_sync,
  output logic [ADDR_W:0]   rgray,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              rd_stat,
  output logic              almost_empty_n
);
  localparam int PW = ADDR_W + 1;

  logic          rst, ft;
  fifo_mode_e    mode_q;
  logic [PW-1:0] rbin_q, rgray_q, wbin, rbin_nxt, rcount_nxt;
  logic          empty_q, ae_n_q, ov_q, fetch;

  assign rst = mrst | prst;

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= mode_sel ? MODE_FWFT : MODE_STD;
  end
  assign ft = (mode_q == MODE_FWFT);

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_sync >> i);
  end

  assign fetch      = ~empty_q & ~retx & (ft ? (~ov_q | rd_en) : rd_en);
  assign rbin_nxt   = retx ? '0 : rbin_q + {{(PW-1){1'b0}}, fetch};
  assign rcount_nxt = wbin - rbin_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      ae_n_q  <= 1'b0;
      ov_q    <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      empty_q <= retx | (rcount_nxt == '0);
      ae_n_q  <= !(rcount_nxt < empty_off);
      if (retx)       ov_q <= 1'b0;
      else if (fetch) ov_q <= 1'b1;
      else if (rd_en) ov_q <= 1'b0;
    end
  end

  assign rgray          = rgray_q;
  assign mem_re         = fetch;
  assign mem_raddr      = rbin_q[ADDR_W-1:0];
  assign rd_stat        = ft ? ~ov_q : ~empty_q;
  assign almost_empty_n = ae_n_q;

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    fetch |-> (wbin != rbin_q));

  // R4
  retx_empty_chk: assert property (@(posedge clk) disable iff (rst)
    retx |=> (empty_q && !ov_q));

  // R8
  ov_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_q) |-> $past(fetch));

  // R2
  rd_mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
    !mrst |=> $stable(mode_q));
endmodule

// File: rtl/twoclk_fifo.sv
module twoclk_fifo #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              mode_sel,
  input  logic [ADDR_W:0]   full_off,
  input  logic [ADDR_W:0]   empty_off,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              retx,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_stat,
  output logic              rd_stat,
  output logic              almost_full_n,
  output logic              almost_empty_n,
  output logic              half_full_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
  logic              mem_we, mem_re, dom_rst;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;

  assign dom_rst = mrst | prst;

  twoclk_fifo_wr #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
    .wr_en(wr_en), .full_off(full_off), .rgray_sync(rgray_ws),
    .wgray(wgray), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wr_stat(wr_stat), .almost_full_n(almost_full_n),
    .half_full_n(half_full_n)
  );

  twoclk_fifo_rd #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
    .rd_en(rd_en), .retx(retx), .empty_off(empty_off),
    .wgray_sync(wgray_rs), .rgray(rgray), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .rd_stat(rd_stat),
    .almost_empty_n(almost_empty_n)
  );

  twoclk_fifo_sync #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst(dom_rst), .d(wgray), .q(wgray_rs)
  );

  twoclk_fifo_sync #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst(dom_rst), .d(rgray), .q(rgray_ws)
  );

  twoclk_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(dom_rst), .re(mem_re), .raddr(mem_raddr),
    .q(rd_data)
  );
endmodule

// File: tb/twoclk_fifo_test.sv
module twoclk_fifo_test;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, mode_sel = 1'b0;
  logic [AW:0] full_off = 5'd3, empty_off = 5'd3;
  logic wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_stat, rd_stat, almost_full_n, almost_empty_n, half_full_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 wr_clk = ~wr_clk;
  always #5 rd_clk = ~rd_clk;

  twoclk_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst(mrst), .prst(prst),
    .mode_sel(mode_sel), .full_off(full_off), .empty_off(empty_off),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .retx(retx),
    .rd_data(rd_data), .wr_stat(wr_stat), .rd_stat(rd_stat),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
    .half_full_n(half_full_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic do_reset(input bit master, input bit mode);
    @(negedge rd_clk);
    mode_sel = mode;
    if (master) mrst = 1'b1; else prst = 1'b1;
    repeat (4) @(negedge rd_clk);
    mrst = 1'b0;
    prst = 1'b0;
    settle();
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_std(input string req, input int exp);
    rd_pulse();
    chk(req, rd_data, exp);
  endtask

  task automatic t_std_basic();
    do_reset(1'b1, 1'b0);
    chk("R1 rd_data zero", rd_data, 0);
    chk("R1 rd_stat empty", rd_stat, 0);
    chk("R1 wr_stat", wr_stat, 1);
    chk("R1 almost_empty_n", almost_empty_n, 0);
    chk("R1 almost_full_n", almost_full_n, 1);
    chk("R1 half_full_n", half_full_n, 1);
    for (int i = 0; i < 5; i++) wr_word(DW'(9'h101 + i));
    settle();
    chk("R6 std not empty", rd_stat, 1);
    for (int i = 0; i < 5; i++) rd_std("R7 order", 9'h101 + i);
    settle();
    chk("R6 std empty again", rd_stat, 0);
    rd_pulse();
    chk("R7 empty read ignored", rd_data, 9'h105);
  endtask

  task automatic t_thresholds();
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 2; i++) wr_word(DW'(i));
    settle();
    chk("R11 count 2 below n", almost_empty_n, 0);
    wr_word(9'd2);
    settle();
    chk("R11 count 3 at n", almost_empty_n, 1);
    for (int i = 3; i < 8; i++) wr_word(DW'(i));
    settle();
    chk("R12 count 8", half_full_n, 1);
    wr_word(9'd8);
    settle();
    chk("R12 count 9", half_full_n, 0);
    for (int i = 9; i < 13; i++) wr_word(DW'(i));
    settle();
    chk("R10 count 13", almost_full_n, 1);
    wr_word(9'd13);
    settle();
    chk("R10 count 14", almost_full_n, 0);
  endtask

  task automatic t_std_full();
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++) wr_word(DW'(i * 7 + 1));
    settle();
    chk("R5 std full", wr_stat, 0);
    wr_word(9'h1FF);
    for (int i = 0; i < DEPTH; i++) rd_std("R9 drain order", (i * 7 + 1) & 9'h1FF);
    settle();
    chk("R9 extra word discarded", rd_stat, 0);
    chk("R5 std not full", wr_stat, 1);
  endtask

  task automatic t_retx();
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) wr_word(DW'(9'h0C0 + i));
    settle();
    for (int i = 0; i < 3; i++) rd_std("R4 pre-read", 9'h0C0 + i);
    @(negedge rd_clk);
    retx = 1'b1;
    @(negedge rd_clk);
    retx = 1'b0;
    chk("R4 empty shown after retx", rd_stat, 0);
    settle();
    chk("R4 data again", rd_stat, 1);
    for (int i = 0; i < 6; i++) rd_std("R4 reread", 9'h0C0 + i);
  endtask

  task automatic t_fwft();
    do_reset(1'b1, 1'b1);
    chk("R1 fwft rd_data zero", rd_data, 0);
    chk("R5 fwft room", wr_stat, 0);
    chk("R6 fwft no data", rd_stat, 1);
    wr_word(9'h0AA);
    settle();
    chk("R8 fall-through valid", rd_stat, 0);
    chk("R8 fall-through word", rd_data, 9'h0AA);
    rd_pulse();
    settle();
    chk("R6 fwft drained", rd_stat, 1);
    wr_word(9'h100);
    settle();
    for (int i = 1; i <= DEPTH; i++) wr_word(DW'(9'h100 + i));
    settle();
    chk("R5 fwft no room", wr_stat, 1);
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R8 fwft valid", rd_stat, 0);
      chk("R8 fwft order", rd_data, 9'h100 + i);
      rd_pulse();
      repeat (4) @(negedge rd_clk);
    end
    chk("R8 fwft empty after DEPTH+1", rd_stat, 1);
  endtask

  task automatic t_partial();
    wr_word(9'h033);
    settle();
    do_reset(1'b0, 1'b0);
    chk("R3 rd_data zero", rd_data, 0);
    chk("R3 mode kept, no data", rd_stat, 1);
    wr_word(9'h044);
    settle();
    chk("R2 still fall-through", rd_stat, 0);
    chk("R3 word without read", rd_data, 9'h044);
    do_reset(1'b1, 1'b0);
    chk("R2 standard again", rd_stat, 0);
    chk("R2 standard wr_stat", wr_stat, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_std_basic();
    t_thresholds();
    t_std_full();
    t_retx();
    t_fwft();
    t_partial();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule